// File: doc/BRIEF.md
# S/PDIF Subframe Error Concealment

This block follows an S/PDIF bi-phase decoder and takes one decoded subframe per input strobe. Each subframe carries a channel tag, a 24-bit audio sample, the validity, user and channel-status bits, the received parity bit, and a flag from the decoder that marks a bi-phase coding fault. The block checks the subframe parity on its own and then produces two registered streams.

The converter stream feeds the digital-to-analogue and serial audio side. It treats a subframe as bad when the parity check fails, when the decoder flags a bi-phase fault, or when the validity bit is set. The retransmit stream feeds an S/PDIF transmitter and treats a subframe as bad only when its validity bit is set. Subframes with parity or coding faults pass through that stream unchanged.

Each stream keeps its own last-good sample for each channel. A bad subframe is replaced by that stored sample, never by silence. Both streams are valid-only outputs with no back-pressure: the block accepts a subframe on every cycle where `in_valid` is high, and each downstream consumer must take every output strobe as it arrives.

Top module: `spdif_conceal`

## Requirements
- R1: Each input strobe produces exactly one strobe on each output stream, one clock later. The output carries the input's channel tag (0 = left, 1 = right). With no input strobe there is no output strobe.
- R2: Parity is even over the 24 sample bits plus the validity, user, channel-status and parity bits. An odd count of ones makes the converter stream substitute.
- R3: A subframe with the bi-phase fault flag set makes the converter stream substitute.
- R4: A subframe with the validity bit equal to 1 makes both streams substitute.
- R5: The retransmit stream outputs the received sample unchanged, with its substitute flag 0, for any subframe whose validity bit is 0. This holds even when the subframe has a parity or bi-phase fault.
- R6: A substituted output equals the most recent sample that the same stream accepted as good on the same channel. Samples from the other channel never affect it.
- R7: Each stream's stored sample updates only on subframes that this stream judges good. A subframe bad for the converter stream but good for the retransmit stream updates only the retransmit store.
- R8: Reset clears both outputs and all stored samples. A bad subframe that arrives before any good one on its channel therefore outputs zero.
- R9: Each output's substitute flag is 1 exactly when its sample came from the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Single-cycle subframe strobe |
| in_chan | input | 1 | Channel tag, 0 left, 1 right |
| in_sample | input | 24 | Decoded audio sample |
| in_validity | input | 1 | Validity bit, 1 = invalid data |
| in_user | input | 1 | User data bit |
| in_status | input | 1 | Channel-status bit |
| in_parity | input | 1 | Received parity bit |
| in_biphase_err | input | 1 | Bi-phase coding fault from the decoder |
| conv_valid | output | 1 | Converter stream strobe |
| conv_chan | output | 1 | Converter stream channel tag |
| conv_sample | output | 24 | Converter stream sample |
| conv_subst | output | 1 | Converter sample was substituted |
| retx_valid | output | 1 | Retransmit stream strobe |
| retx_chan | output | 1 | Retransmit stream channel tag |
| retx_sample | output | 24 | Retransmit stream sample |
| retx_subst | output | 1 | Retransmit sample was substituted |

## Verification
The vector walk sends clean subframes, parity-only faults, coding-only faults, validity-only faults and combined faults, interleaved across both channels. A parity or coding fault is the case that separates the two streams: the converter repeats its stored sample while the retransmit stream passes the new one through and stores it. A later validity fault on the same channel then shows that the two stores have diverged. Clean subframes that set the user and status bits show that those bits count in the parity. Directed tests cover reset, a bad subframe before any good one, idle cycles, and back-to-back strobes.

// File: rtl/spdif_conceal_pkg.sv
package spdif_conceal_pkg;
  localparam int SAMPLE_W = 24;
  localparam int NUM_CH   = 2;
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [CH_W-1:0]     chan_t;
endpackage

// File: rtl/spdif_parity_check.sv
module spdif_parity_check #(
  parameter int W = 24
) (
  input  logic [W-1:0] sample,
  input  logic         validity,
  input  logic         user,
  input  logic         status,
  input  logic         parity,
  output logic         err
);
  // even parity across the payload and flag bits; an odd total is a fault
  always_comb err = ^{sample, validity, user, status, parity};
endmodule

// File: rtl/spdif_hold_path.sv
module spdif_hold_path #(
  parameter int W   = 24,
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_chan,
  input  logic [W-1:0]   in_sample,
  input  logic           in_bad,
  output logic           out_valid,
  output logic [CHW-1:0] out_chan,
  output logic [W-1:0]   out_sample,
  output logic           out_subst
);
  logic [W-1:0] hold_q [NCH];
  logic [W-1:0] held;

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)
        hold_q[g] <= '0;
      else if (in_valid && !in_bad && (in_chan == CHW'(g)))
        hold_q[g] <= in_sample;
    end
  end

  always_comb begin
    held = '0;
    for (int i = 0; i < NCH; i++)
      if (in_chan == CHW'(i)) held = hold_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
      out_subst  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan   <= in_chan;
        out_subst  <= in_bad;
        out_sample <= in_bad ? held : in_sample;
      end
    end
  end
endmodule

// File: rtl/spdif_conceal.sv
module spdif_conceal
  import spdif_conceal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CH_W-1:0]     in_chan,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_validity,
  input  logic                in_user,
  input  logic                in_status,
  input  logic                in_parity,
  input  logic                in_biphase_err,
  output logic                conv_valid,
  output logic [CH_W-1:0]     conv_chan,
  output logic [SAMPLE_W-1:0] conv_sample,
  output logic                conv_subst,
  output logic                retx_valid,
  output logic [CH_W-1:0]     retx_chan,
  output logic [SAMPLE_W-1:0] retx_sample,
  output logic                retx_subst
);
  logic par_err;
  logic conv_bad;
  logic retx_bad;

  spdif_parity_check #(.W(SAMPLE_W)) u_par (
    .sample   (in_sample),
    .validity (in_validity),
    .user     (in_user),
    .status   (in_status),
    .parity   (in_parity),
    .err      (par_err)
  );

  always_comb begin
    conv_bad = par_err | in_biphase_err | in_validity;
    retx_bad = in_validity;
  end

  spdif_hold_path #(.W(SAMPLE_W), .NCH(NUM_CH), .CHW(CH_W)) u_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .in_sample  (in_sample),
    .in_bad     (conv_bad),
    .out_valid  (conv_valid),
    .out_chan   (conv_chan),
    .out_sample (conv_sample),
    .out_subst  (conv_subst)
  );

  spdif_hold_path #(.W(SAMPLE_W), .NCH(NUM_CH), .CHW(CH_W)) u_retx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_chan    (in_chan),
    .in_sample  (in_sample),
    .in_bad     (retx_bad),
    .out_valid  (retx_valid),
    .out_chan   (retx_chan),
    .out_sample (retx_sample),
    .out_subst  (retx_subst)
  );
endmodule

// File: rtl/spdif_conceal_chk.sv
module spdif_conceal_chk
  import spdif_conceal_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [CH_W-1:0]     in_chan,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                in_validity,
  input logic                in_user,
  input logic                in_status,
  input logic                in_parity,
  input logic                in_biphase_err,
  input logic                conv_valid,
  input logic [CH_W-1:0]     conv_chan,
  input logic [SAMPLE_W-1:0] conv_sample,
  input logic                conv_subst,
  input logic                retx_valid,
  input logic [CH_W-1:0]     retx_chan,
  input logic [SAMPLE_W-1:0] retx_sample,
  input logic                retx_subst
);
  // R1
  out_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (conv_valid && retx_valid));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!conv_valid && !retx_valid));

  // R1
  chan_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (conv_chan == $past(in_chan) && retx_chan == $past(in_chan)));

  // R2
  parity_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (^{in_sample, in_validity, in_user, in_status, in_parity})) |=> conv_subst);

  // R3
  biphase_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_biphase_err) |=> conv_subst);

  // R4
  validity_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_validity) |=> (conv_subst && retx_subst));

  // R5
  retx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_validity) |=> (!retx_subst && retx_sample == $past(in_sample)));

  // R9
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !conv_subst) |=> (conv_sample == $past(in_sample) || conv_subst));
endmodule

bind spdif_conceal spdif_conceal_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
  .in_sample(in_sample), .in_validity(in_validity), .in_user(in_user),
  .in_status(in_status), .in_parity(in_parity), .in_biphase_err(in_biphase_err),
  .conv_valid(conv_valid), .conv_chan(conv_chan), .conv_sample(conv_sample),
  .conv_subst(conv_subst), .retx_valid(retx_valid), .retx_chan(retx_chan),
  .retx_sample(retx_sample), .retx_subst(retx_subst)
);

// File: tb/test_spdif_conceal.sv
module test_spdif_conceal;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_chan, in_validity, in_user, in_status, in_parity, in_biphase_err;
  logic [23:0] in_sample;
  logic        conv_valid, conv_chan, conv_subst, retx_valid, retx_chan, retx_subst;
  logic [23:0] conv_sample, retx_sample;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  spdif_conceal i_spdif_conceal (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_sample(in_sample), .in_validity(in_validity), .in_user(in_user),
    .in_status(in_status), .in_parity(in_parity), .in_biphase_err(in_biphase_err),
    .conv_valid(conv_valid), .conv_chan(conv_chan), .conv_sample(conv_sample),
    .conv_subst(conv_subst), .retx_valid(retx_valid), .retx_chan(retx_chan),
    .retx_sample(retx_sample), .retx_subst(retx_subst)
  );

  typedef struct packed {
    logic        ch;
    logic [23:0] smp;
    logic        v, u, c, pflip, bp;
    logic [23:0] exp_c;
    logic        exp_cs;
    logic [23:0] exp_r;
    logic        exp_rs;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 24'h111111, 1'b0,1'b0,1'b0,1'b0,1'b1, 24'h000000,1'b1, 24'h111111,1'b0}, // R8 R3 R5
    '{1'b1, 24'h222222, 1'b1,1'b0,1'b0,1'b0,1'b0, 24'h000000,1'b1, 24'h000000,1'b1}, // R8 R4
    '{1'b0, 24'h100001, 1'b0,1'b0,1'b0,1'b0,1'b0, 24'h100001,1'b0, 24'h100001,1'b0}, // R9
    '{1'b1, 24'h200002, 1'b0,1'b0,1'b0,1'b0,1'b0, 24'h200002,1'b0, 24'h200002,1'b0}, // R9
    '{1'b0, 24'h333333, 1'b0,1'b0,1'b0,1'b1,1'b0, 24'h100001,1'b1, 24'h333333,1'b0}, // R2 R5
    '{1'b1, 24'h444444, 1'b0,1'b1,1'b1,1'b0,1'b0, 24'h444444,1'b0, 24'h444444,1'b0}, // R2
    '{1'b0, 24'h555555, 1'b1,1'b0,1'b0,1'b0,1'b0, 24'h100001,1'b1, 24'h333333,1'b1}, // R7 R6
    '{1'b1, 24'h666666, 1'b1,1'b0,1'b0,1'b0,1'b1, 24'h444444,1'b1, 24'h444444,1'b1}, // R6
    '{1'b0, 24'h777777, 1'b0,1'b0,1'b0,1'b0,1'b0, 24'h777777,1'b0, 24'h777777,1'b0}, // R9
    '{1'b0, 24'h888888, 1'b0,1'b0,1'b0,1'b1,1'b1, 24'h777777,1'b1, 24'h888888,1'b0}, // R5
    '{1'b1, 24'hABCDEF, 1'b1,1'b0,1'b0,1'b1,1'b0, 24'h444444,1'b1, 24'h444444,1'b1}, // R4
    '{1'b1, 24'hFEDCBA, 1'b0,1'b0,1'b1,1'b0,1'b0, 24'hFEDCBA,1'b0, 24'hFEDCBA,1'b0}  // R6
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    in_valid       = 1'b1;
    in_chan        = t.ch;
    in_sample      = t.smp;
    in_validity    = t.v;
    in_user        = t.u;
    in_status      = t.c;
    in_biphase_err = t.bp;
    in_parity      = (^{t.smp, t.v, t.u, t.c}) ^ t.pflip;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_chan = 1'b0; in_sample = '0; in_validity = 1'b0;
    in_user = 1'b0; in_status = 1'b0; in_parity = 1'b0; in_biphase_err = 1'b0;
  endtask

  task automatic check_out(input string req, input vec_t t);
    check({req, " conv"}, {1'b0, conv_valid, conv_chan, conv_sample, conv_subst},
          {1'b0, 1'b1, t.ch, t.exp_c, t.exp_cs});
    check({req, " retx"}, {1'b0, retx_valid, retx_chan, retx_sample, retx_subst},
          {1'b0, 1'b1, t.ch, t.exp_r, t.exp_rs});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t t;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 reset", {conv_valid, conv_sample, retx_valid, retx_sample}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      check_out($sformatf("vec%0d R1", k), VECS[k]);
    end

    // R1: no strobe gives no output
    idle();
    @(negedge clk);
    check("R1 idle", {conv_valid, retx_valid}, 2'b00);
    @(negedge clk);
    check("R1 idle2", {conv_valid, retx_valid}, 2'b00);

    // R6: right-channel fault repeats right store, not left
    t = '{1'b1, 24'h0F0F0F, 1'b0,1'b0,1'b0,1'b0,1'b1, 24'hFEDCBA,1'b1, 24'h0F0F0F,1'b0};
    drive(t);
    @(negedge clk);
    check_out("R6 right", t);
    // back-to-back: left fault right after
    t = '{1'b0, 24'h121212, 1'b1,1'b0,1'b0,1'b0,1'b0, 24'h777777,1'b1, 24'h888888,1'b1};
    drive(t);
    @(negedge clk);
    check_out("R7 b2b", t);
    idle();

    // R8: reset clears stores
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset2", {conv_valid, retx_valid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    t = '{1'b0, 24'h999999, 1'b1,1'b0,1'b0,1'b0,1'b0, 24'h000000,1'b1, 24'h000000,1'b1};
    drive(t);
    @(negedge clk);
    check_out("R8 cleared", t);
    idle();
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule